// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns an already qualified PWM level and a conduction-mode select into the high-side and low-side gate enables of a synchronous buck power stage. Dead time is not a fixed delay. Each time one switch must hand over to the other, the block first drops the conducting gate. It then waits until a digitised comparator flag reports that this gate, or the switch node, has fallen below its threshold. Only after that flag has held for a programmable number of cycles does it raise the complementary gate. A timeout bounds every such wait, so a missing flag cannot stall the stage.

In continuous mode the two gates follow the PWM level in a complementary way. In diode-emulation mode the high side is driven exactly as in continuous mode. A PWM low phase turns the low side on once, keeps it on for a minimum on-time, and then releases it when the zero-cross flag reports that inductor current has reached zero. Both gates then stay low until the next PWM rising edge. A forced-off input overrides everything and parks both gates low. All state and both outputs are registered. The feedback flags are expected to arrive already synchronised to the block clock.

Top module: `gate_seq_top`

## Requirements
- R1: When PWM goes high, ls_en_o drops first and hs_en_o rises only after ls_below_i has been high for DT_CYC consecutive cycles. With the flag high throughout, ls_en_o is low in the cycle after PWM high is sampled and hs_en_o rises DT_CYC+1 cycles after that.
- R2: When PWM goes low, hs_en_o drops first and ls_en_o rises only after sw_below_i has been high for DT_CYC consecutive cycles. The timing is the same as in R1.
- R3: In continuous mode (dem_mode_i = 0) a steady PWM high yields hs_en_o = 1, ls_en_o = 0, and a steady PWM low yields hs_en_o = 0, ls_en_o = 1. This includes the case where the block starts from both-off with PWM low.
- R4: In diode-emulation mode (dem_mode_i = 1), PWM high drives the gates as in R3. After a PWM falling edge the low side turns on and stays on while zcd_i is low. Once the minimum on-time has elapsed, a high zcd_i turns it off, leaving both gates low until PWM rises again.
- R5: In diode-emulation mode ls_en_o stays high for at least MINON_CYC cycles. With zcd_i held high, it falls exactly MINON_CYC+1 cycles after it rose.
- R6: hs_en_o and ls_en_o are never high in the same cycle.
- R7: A high force_off_i drives both outputs low at the next clock edge and keeps them low while it stays high, whatever PWM does. When it is released, sequencing restarts from both-off.
- R8: If the awaited below-threshold flag never arrives, the complementary gate turns on TMO_CYC+1 cycles after the wait began.
- R9: A PWM reversal during a dead-time wait aborts that wait and starts the opposite hand-over from the both-off condition. The gate that was being waited for never pulses.
- R10: While rst_ni is low, both outputs are low, and after reset the block starts from the both-off state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sequencer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | Qualified PWM level, 1 = high-side phase |
| dem_mode_i | input | 1 | 1 = diode emulation, 0 = continuous conduction |
| force_off_i | input | 1 | 1 = shut both gates off |
| ls_below_i | input | 1 | 1 = low-side gate sensed below threshold |
| sw_below_i | input | 1 | 1 = high-side gate / switch node sensed below threshold |
| zcd_i | input | 1 | 1 = inductor current has reached zero |
| hs_en_o | output | 1 | High-side gate enable (registered) |
| ls_en_o | output | 1 | Low-side gate enable (registered) |

## Verification
On every cycle, the assertions check that the two enables are never high together and that force-off clears both on the next edge. They also check that each gate rises only after the other was already low with PWM at the matching level. In diode-emulation mode they check that a low-side release without a PWM edge happens only on a zero-cross and only after the minimum on-time, which a run-length counter in the checker measures. The bench scenarios are the only place where the exact dead-time and timeout cycle counts, the abort of a pending wait, and the idle both-off state after a zero-cross are shown.

// File: rtl/gseq_pkg.sv
package gseq_pkg;

   typedef enum logic [2:0] {
      ST_OFF = 3'd0,   // both gates low, idle
      ST_HI  = 3'd1,   // high side conducting
      ST_WLO = 3'd2,   // waiting for low-side gate to fall
      ST_LO  = 3'd3,   // low side conducting
      ST_WHO = 3'd4    // waiting for high-side gate / switch node to fall
   } gseq_st_e;

   // counter width that can hold the value lim (at least one bit)
   function automatic int cnt_w(input int lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/gseq_tmr.sv
module gseq_tmr #(
   parameter int LIMIT = 4
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   output logic done_o
);
   localparam int W = gseq_pkg::cnt_w(LIMIT);

   generate
      if (LIMIT == 0) begin : g_zero
         // no waiting needed: always expired
         logic unused_tmr;
         assign unused_tmr = ^{clk_i, rst_ni, clr_i};
         assign done_o = 1'b1;
      end else begin : g_cnt
         logic [W-1:0] cnt_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                  cnt_q <= '0;
            else if (clr_i)               cnt_q <= '0;
            else if (cnt_q != W'(LIMIT))  cnt_q <= cnt_q + W'(1);
         end
         assign done_o = (cnt_q == W'(LIMIT));
      end
   endgenerate
endmodule

// File: rtl/gseq_fsm.sv
module gseq_fsm
   import gseq_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     pwm_i,
   input  logic     dem_i,
   input  logic     frc_i,
   input  logic     ls_below_i,
   input  logic     sw_below_i,
   input  logic     zcd_i,
   input  logic     fb_done_i,
   input  logic     tmo_done_i,
   input  logic     min_done_i,
   output gseq_st_e st_o,
   output gseq_st_e st_nxt_o,
   output logic     fb_ok_o,
   output logic     hs_o,
   output logic     ls_o
);
   gseq_st_e st_q, st_d;
   logic     go;

   assign go = fb_done_i | tmo_done_i;

   always_comb begin
      unique case (st_q)
         ST_WLO:  fb_ok_o = ls_below_i;
         ST_WHO:  fb_ok_o = sw_below_i;
         default: fb_ok_o = 1'b0;
      endcase
   end

   always_comb begin
      st_d = st_q;
      if (frc_i) begin
         st_d = ST_OFF;
      end else begin
         unique case (st_q)
            ST_OFF: if (pwm_i)       st_d = ST_WLO;
                    else if (!dem_i) st_d = ST_WHO;
            ST_HI:  if (!pwm_i)      st_d = ST_WHO;
            ST_WLO: if (!pwm_i)      st_d = ST_WHO;
                    else if (go)     st_d = ST_HI;
            ST_WHO: if (pwm_i)       st_d = ST_WLO;
                    else if (go)     st_d = ST_LO;
            ST_LO:  if (pwm_i)       st_d = ST_WLO;
                    else if (dem_i && min_done_i && zcd_i) st_d = ST_OFF;
            default:                 st_d = ST_OFF;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= ST_OFF;
         hs_o <= 1'b0;
         ls_o <= 1'b0;
      end else begin
         st_q <= st_d;
         hs_o <= (st_d == ST_HI);
         ls_o <= (st_d == ST_LO);
      end
   end

   assign st_o     = st_q;
   assign st_nxt_o = st_d;
endmodule

// File: rtl/gate_seq_top.sv
module gate_seq_top
   import gseq_pkg::*;
#(
   parameter int DT_CYC    = 4,    // cycles the below-threshold flag must hold
   parameter int TMO_CYC   = 40,   // cycles before a wait gives up on the flag
   parameter int MINON_CYC = 70    // low-side minimum on-time in diode emulation
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pwm_i,
   input  logic dem_mode_i,
   input  logic force_off_i,
   input  logic ls_below_i,
   input  logic sw_below_i,
   input  logic zcd_i,
   output logic hs_en_o,
   output logic ls_en_o
);
   generate
      if (DT_CYC < 0 || MINON_CYC < 0) begin : g_bad_neg
         $error("gate_seq_top: cycle counts must not be negative");
      end
      if (TMO_CYC <= DT_CYC) begin : g_bad_tmo
         $error("gate_seq_top: TMO_CYC must exceed DT_CYC");
      end
   endgenerate

   gseq_st_e st_q, st_nxt;
   logic     fb_ok, fb_done, tmo_done, min_done;
   logic     chg, in_wait;
   logic     fb_clr, tmo_clr, min_clr;

   assign chg     = (st_nxt != st_q);
   assign in_wait = (st_q == ST_WLO) || (st_q == ST_WHO);
   assign fb_clr  = chg | ~in_wait | ~fb_ok;
   assign tmo_clr = chg | ~in_wait;
   assign min_clr = chg | (st_q != ST_LO);

   gseq_tmr #(.LIMIT(DT_CYC)) u_fb_tmr (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (fb_clr), .done_o (fb_done)
   );

   gseq_tmr #(.LIMIT(TMO_CYC)) u_tmo_tmr (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (tmo_clr), .done_o (tmo_done)
   );

   gseq_tmr #(.LIMIT(MINON_CYC)) u_min_tmr (
      .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (min_clr), .done_o (min_done)
   );

   gseq_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pwm_i      (pwm_i),
      .dem_i      (dem_mode_i),
      .frc_i      (force_off_i),
      .ls_below_i (ls_below_i),
      .sw_below_i (sw_below_i),
      .zcd_i      (zcd_i),
      .fb_done_i  (fb_done),
      .tmo_done_i (tmo_done),
      .min_done_i (min_done),
      .st_o       (st_q),
      .st_nxt_o   (st_nxt),
      .fb_ok_o    (fb_ok),
      .hs_o       (hs_en_o),
      .ls_o       (ls_en_o)
   );
endmodule

// File: rtl/gseq_chk.sv
module gseq_chk #(
   parameter int MINON_CYC = 70
) (
   input logic clk_i,
   input logic rst_ni,
   input logic pwm_i,
   input logic dem_mode_i,
   input logic force_off_i,
   input logic zcd_i,
   input logic hs_en_o,
   input logic ls_en_o
);
   localparam int RW = gseq_pkg::cnt_w(MINON_CYC);

   // length of the current low-side on run, saturating at the minimum
   logic [RW-1:0] run_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     run_q <= '0;
      else if (!ls_en_o)               run_q <= '0;
      else if (run_q != RW'(MINON_CYC)) run_q <= run_q + RW'(1);
   end

   // R6
   a_r6_never_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(hs_en_o && ls_en_o));

   // R7
   a_r7_force_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      force_off_i |=> (!hs_en_o && !ls_en_o));

   // R1: high side rises only after the low side was already off, with PWM high
   a_r1_hs_after_ls_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_en_o) |-> (!$past(ls_en_o) && $past(pwm_i)));

   // R2: low side rises only after the high side was already off, with PWM low
   a_r2_ls_after_hs_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ls_en_o) |-> (!$past(hs_en_o) && !$past(pwm_i)));

   // R4: in diode emulation a release without PWM edge needs a zero-cross
   a_r4_release_on_zcd: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(ls_en_o) && $past(dem_mode_i) && !$past(pwm_i) && !$past(force_off_i))
      |-> $past(zcd_i));

   // R5: such a release only after the minimum on-time
   a_r5_min_on_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(ls_en_o) && $past(dem_mode_i) && !$past(pwm_i) && !$past(force_off_i))
      |-> (run_q >= RW'(MINON_CYC)));
endmodule

bind gate_seq_top gseq_chk #(.MINON_CYC(MINON_CYC)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .pwm_i       (pwm_i),
   .dem_mode_i  (dem_mode_i),
   .force_off_i (force_off_i),
   .zcd_i       (zcd_i),
   .hs_en_o     (hs_en_o),
   .ls_en_o     (ls_en_o)
);

// File: tb/gate_seq_top_tb_top.sv
`timescale 1ns/1ps
module gate_seq_top_tb_top;
   localparam int DT    = 4;
   localparam int TMO   = 40;
   localparam int MINON = 70;
   localparam int NV    = 10;

   // {pwm,dem,frc,ls_below,sw_below,zcd}, {exp_hs,exp_ls}, hold cycles
   localparam logic [15:0] VEC [NV] = '{
      {6'b000110, 2'b01, 8'd12},   // R3 start from both-off, PWM low
      {6'b100110, 2'b10, 8'd12},   // R3 PWM high
      {6'b000110, 2'b01, 8'd12},   // R3 PWM low
      {6'b110110, 2'b10, 8'd12},   // R4 high side same in emulation
      {6'b010110, 2'b01, 8'd100},  // R4 low side holds without zero-cross
      {6'b010111, 2'b00, 8'd12},   // R4 zero-cross releases low side
      {6'b010110, 2'b00, 8'd12},   // R4 stays both-off with PWM low
      {6'b000110, 2'b01, 8'd12},   // R3 back to continuous
      {6'b101110, 2'b00, 8'd12},   // R7 forced off
      {6'b100110, 2'b10, 8'd12}    // R7 restart after release
   };
   localparam string VTAG [NV] = '{"R3","R3","R3","R4","R4","R4","R4","R3","R7","R7"};

   logic clk = 1'b0;
   logic rst_n;
   logic pwm, dem, frc, lsl, swl, zcd;
   logic hs, ls;
   int   checks = 0;
   int   errors = 0;
   bit   finished = 1'b0;
   bit   overlap = 1'b0;

   always #2.5 clk = ~clk;

   gate_seq_top #(.DT_CYC(DT), .TMO_CYC(TMO), .MINON_CYC(MINON)) dut_i (
      .clk_i (clk), .rst_ni (rst_n), .pwm_i (pwm), .dem_mode_i (dem),
      .force_off_i (frc), .ls_below_i (lsl), .sw_below_i (swl), .zcd_i (zcd),
      .hs_en_o (hs), .ls_en_o (ls)
   );

   always @(negedge clk) if (rst_n && hs && ls) overlap = 1'b1;

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
      end
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0; pwm = 1'b0; dem = 1'b0; frc = 1'b0;
      lsl = 1'b1; swl = 1'b1; zcd = 1'b0;
      waitn(3);
      chk("R10", "hs in reset", hs, 1'b0);
      chk("R10", "ls in reset", ls, 1'b0);
      rst_n = 1'b1;

      // vector table
      for (int i = 0; i < NV; i++) begin
         {pwm, dem, frc, lsl, swl, zcd} = VEC[i][15:10];
         waitn(int'(VEC[i][7:0]));
         chk(VTAG[i], $sformatf("vec %0d hs", i), hs, VEC[i][9]);
         chk(VTAG[i], $sformatf("vec %0d ls", i), ls, VEC[i][8]);
      end
      // now high side on, continuous, flags high

      // R2 exact hand-over timing
      pwm = 1'b0;
      waitn(1);
      chk("R2", "hs off first", hs, 1'b0);
      waitn(DT);
      chk("R2", "ls still off at dead time", ls, 1'b0);
      waitn(1);
      chk("R2", "ls on after dead time", ls, 1'b1);

      // R1 exact hand-over timing
      pwm = 1'b1;
      waitn(1);
      chk("R1", "ls off first", ls, 1'b0);
      waitn(DT);
      chk("R1", "hs still off at dead time", hs, 1'b0);
      waitn(1);
      chk("R1", "hs on after dead time", hs, 1'b1);

      // R8 timeout toward low side
      swl = 1'b0;
      pwm = 1'b0;
      waitn(TMO + 1);
      chk("R8", "ls off before timeout", ls, 1'b0);
      waitn(1);
      chk("R8", "ls on at timeout", ls, 1'b1);

      // R8 timeout toward high side
      lsl = 1'b0;
      pwm = 1'b1;
      waitn(TMO + 1);
      chk("R8", "hs off before timeout", hs, 1'b0);
      waitn(1);
      chk("R8", "hs on at timeout", hs, 1'b1);

      // R9 abort: PWM falls, then rises again before the low side is allowed on
      begin
         bit ls_seen = 1'b0;
         pwm = 1'b0;
         for (int k = 0; k < 10; k++) begin
            waitn(1);
            if (ls) ls_seen = 1'b1;
         end
         pwm = 1'b1;
         for (int k = 0; k < 10; k++) begin
            waitn(1);
            if (ls) ls_seen = 1'b1;
         end
         chk("R9", "hs off while waiting", hs, 1'b0);
         lsl = 1'b1;
         for (int k = 0; k < DT + 2; k++) begin
            waitn(1);
            if (ls) ls_seen = 1'b1;
         end
         chk("R9", "ls never pulsed", ls_seen, 1'b0);
         chk("R9", "hs on after abort", hs, 1'b1);
      end
      swl = 1'b1;

      // R5 minimum on-time with zero-cross held high
      dem = 1'b1;
      zcd = 1'b1;
      pwm = 1'b0;
      waitn(DT + 2);
      chk("R5", "ls on", ls, 1'b1);
      waitn(MINON);
      chk("R5", "ls held through minimum", ls, 1'b1);
      waitn(1);
      chk("R5", "ls released after minimum", ls, 1'b0);
      chk("R4", "hs low after release", hs, 1'b0);
      zcd = 1'b0;

      // R7 force with toggling PWM
      dem = 1'b0;
      pwm = 1'b1;
      waitn(12);
      frc = 1'b1;
      waitn(1);
      chk("R7", "hs cleared next edge", hs, 1'b0);
      for (int k = 0; k < 6; k++) begin
         pwm = ~pwm;
         waitn(5);
      end
      chk("R7", "hs held low", hs, 1'b0);
      chk("R7", "ls held low", ls, 1'b0);
      frc = 1'b0;
      waitn(12);

      // R10 reset in operation
      rst_n = 1'b0;
      waitn(1);
      chk("R10", "hs after mid-run reset", hs, 1'b0);
      chk("R10", "ls after mid-run reset", ls, 1'b0);
      rst_n = 1'b1;
      pwm = 1'b1;
      waitn(DT + 2);
      chk("R10", "restart from both-off", hs, 1'b1);

      chk("R6", "no overlap seen", overlap, 1'b0);
      finish_run();
   end
endmodule